// File: doc/BRIEF.md
# SMBus Host Block-Transfer Controller

This block is the host side of an SMBus segment, seen by software as a small byte-wide register window. Software loads a target address, a command byte and a byte count, fills a 32-byte block buffer through a single data port, and then sets a start bit. The controller performs a complete block-write or block-read transaction and records the outcome in a status register whose flags software clears by writing ones.

The block does not generate SCL or SDA itself. It issues bus operations (start condition, byte write, byte read with a choice of ACK or NACK, stop condition) to a byte-level I2C master over a request/done handshake. It takes back a NACK indication and the received byte. A block read places the count returned by the target in data register 0 and the data bytes in the buffer. Software then rewinds the buffer index by reading the control register and drains the bytes through the data port.

Top module: `smbus_blk_host`

## Requirements
- R1: Registers sit at byte offsets status 0x0, control 0x2, command 0x3, target 0x4, data0 0x5, data1 0x6, block port 0x7 and auxiliary 0xD. After reset, status and control read 0x00 and no bus request is raised.
- R2: Control bits [4:2] select the protocol, and block transfer is 5. Bit 6 is start, bit 1 is kill, bit 0 is interrupt enable, bit 5 is last-byte and bit 7 is PEC enable. A start with target bit 0 clear runs a block write. Its bus operations are a START (op 0), a write (op 1) of {target[7:1],0}, the command, the data0 count and the buffer bytes in order, then a STOP (op 3). A successful finish sets complete (status bit 1).
- R3: A start with target bit 0 set runs a block read. The bus operations are START, write {target[7:1],0}, write command, START, write {target[7:1],1}, then a read (op 2) of the count byte and one read per counted byte, with the last-byte NACK line high only on the final data read, then STOP. The count is left in data0 and the bytes are placed in the buffer from index 0.
- R4: A read of control sets the buffer index to 0. Each read or write of the block port moves one byte and advances the index when auxiliary bit 1 is set; when that bit is clear the index does not move.
- R5: A NACK on any byte the controller transmits ends the transaction with a STOP and sets device-error (status bit 2) instead of complete.
- R6: During a block read, a received count of 0 or above 32 ends the transaction with a STOP right after the count byte and sets failed (status bit 4).
- R7: Writing control with bit 1 set during a transaction makes the next bus operation a STOP. Busy then clears and failed is set.
- R8: A start while busy is ignored, and so are writes to command, target and data0; the running transaction continues unchanged.
- R9: Status bit 0 (busy) reads 1 while a transaction runs and is not writable. Bits 6, 4, 2 and 1 clear only where a 1 is written.
- R10: Every read of status sets in-use (status bit 6) after returning the old value.
- R11: A start with a protocol other than 5, or a write start with data0 of 0 or above 32, sets failed at once and raises no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on the clock edge) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| bus_req | output | 1 | Bus operation requested, held until bus_done |
| bus_op | output | 2 | 0 START, 1 write byte, 2 read byte, 3 STOP |
| bus_txd | output | 8 | Byte to transmit for a write operation |
| bus_last | output | 1 | Answer the read byte with NACK |
| bus_done | input | 1 | One-cycle completion of the requested operation |
| bus_nack | input | 1 | Target did not acknowledge the written byte |
| bus_rxd | input | 8 | Byte received by a read operation, valid with bus_done |

## Verification
A sequencer that skips, repeats or reorders a state shows up at the bus port on the very next completed handshake. The next op code or byte differs from the expected list, or a STOP arrives early or late. A wrong transfer index shows up as a wrong data byte or a misplaced NACK on the following operation. A wrong index on the software side appears at the next block port read. An outcome latched incorrectly during the transaction appears only when the STOP completes, as the wrong status flag on the following status read.

// File: rtl/smbus_blk_host.sv
module smbus_blk_host #(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       bus_req,
  output logic [1:0] bus_op,
  output logic [7:0] bus_txd,
  output logic       bus_last,
  input  logic       bus_done,
  input  logic       bus_nack,
  input  logic [7:0] bus_rxd
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [8:0] MAXCNT = 9'(DEPTH);
  localparam logic [2:0] PROT_BLOCK = 3'd5;
  localparam logic [1:0] OP_START = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_STOP = 2'd3;
  localparam logic [1:0] RES_OK = 2'd0, RES_DEV = 2'd1, RES_FAIL = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_CMD, S_CNT, S_WDATA,
    S_RSTART, S_RADDR, S_RCNT, S_RDATA, S_STOP
  } state_t;

  state_t state;
  logic [7:0] cmd_r, tgt_r, d0_r, d1_r, aux_r, xidx;
  logic [2:0] prot_r;
  logic ie_r, kill_r, last_r, pec_r, kill_pend, rd_dir;
  logic st_inuse, st_fail, st_dev, st_intr;
  logic [1:0] res;
  logic [IW-1:0] bidx;
  logic [7:0] mem [DEPTH];

  wire busy    = state != S_IDLE;
  wire ctl_wr  = reg_wr && reg_addr == 4'h2;
  wire go      = ctl_wr && reg_wdata[6] && !busy;
  wire bad_cnt = d0_r == 8'd0 || {1'b0, d0_r} > MAXCNT;
  wire bad     = reg_wdata[4:2] != PROT_BLOCK || (!tgt_r[0] && bad_cnt);
  wire port_wr = reg_wr && reg_addr == 4'h7 && !busy;
  wire port_mv = (reg_wr || reg_rd) && reg_addr == 4'h7 && !busy;
  wire fsm_wr  = bus_done && state == S_RDATA;
  wire at_end  = xidx + 8'd1 == d0_r;

  assign bus_req  = busy;
  assign bus_last = state == S_RDATA && at_end;

  always_comb begin
    case (state)
      S_START, S_RSTART: bus_op = OP_START;
      S_RCNT, S_RDATA:   bus_op = OP_RD;
      S_STOP:            bus_op = OP_STOP;
      default:           bus_op = OP_WR;
    endcase
    case (state)
      S_ADDR:  bus_txd = {tgt_r[7:1], 1'b0};
      S_RADDR: bus_txd = {tgt_r[7:1], 1'b1};
      S_CMD:   bus_txd = cmd_r;
      S_CNT:   bus_txd = d0_r;
      S_WDATA: bus_txd = mem[xidx[IW-1:0]];
      default: bus_txd = 8'h00;
    endcase
    case (reg_addr)
      4'h0:    reg_rdata = {1'b0, st_inuse, 1'b0, st_fail, 1'b0, st_dev, st_intr, busy};
      4'h2:    reg_rdata = {pec_r, 1'b0, last_r, prot_r, kill_r, ie_r};
      4'h3:    reg_rdata = cmd_r;
      4'h4:    reg_rdata = tgt_r;
      4'h5:    reg_rdata = d0_r;
      4'h6:    reg_rdata = d1_r;
      4'h7:    reg_rdata = mem[bidx];
      4'hD:    reg_rdata = aux_r;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (fsm_wr) mem[xidx[IW-1:0]] <= bus_rxd;
    else if (port_wr) mem[bidx] <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      {cmd_r, tgt_r, d0_r, d1_r, aux_r, xidx} <= '0;
      {prot_r, ie_r, kill_r, last_r, pec_r, kill_pend, rd_dir} <= '0;
      {st_inuse, st_fail, st_dev, st_intr} <= '0;
      res  <= RES_OK;
      bidx <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          4'h0: begin
            if (reg_wdata[6]) st_inuse <= 1'b0;
            if (reg_wdata[4]) st_fail  <= 1'b0;
            if (reg_wdata[2]) st_dev   <= 1'b0;
            if (reg_wdata[1]) st_intr  <= 1'b0;
          end
          4'h2: {pec_r, last_r, prot_r, kill_r, ie_r} <= {reg_wdata[7], reg_wdata[5:0]};
          4'h3: if (!busy) cmd_r <= reg_wdata;
          4'h4: if (!busy) tgt_r <= reg_wdata;
          4'h5: if (!busy) d0_r <= reg_wdata;
          4'h6: d1_r <= reg_wdata;
          4'hD: aux_r <= reg_wdata;
          default: ;
        endcase
      end
      if (reg_rd && reg_addr == 4'h0) st_inuse <= 1'b1;
      if (reg_rd && reg_addr == 4'h2) bidx <= '0;
      else if (port_mv && aux_r[1]) bidx <= bidx + 1'b1;
      if (ctl_wr && reg_wdata[1] && busy) kill_pend <= 1'b1;

      if (go) begin
        if (bad) st_fail <= 1'b1;
        else begin
          state <= S_START;
          rd_dir <= tgt_r[0];
          res <= RES_OK;
          kill_pend <= 1'b0;
          xidx <= '0;
        end
      end

      if (bus_done && busy) begin
        case (state)
          S_START:  state <= S_ADDR;
          S_ADDR:   if (bus_nack) begin state <= S_STOP; res <= RES_DEV; end
                    else state <= S_CMD;
          S_CMD:    if (bus_nack) begin state <= S_STOP; res <= RES_DEV; end
                    else state <= rd_dir ? S_RSTART : S_CNT;
          S_CNT:    if (bus_nack) begin state <= S_STOP; res <= RES_DEV; end
                    else begin state <= S_WDATA; xidx <= '0; end
          S_WDATA:  begin
                      xidx <= xidx + 8'd1;
                      if (bus_nack) begin state <= S_STOP; res <= RES_DEV; end
                      else if (at_end) state <= S_STOP;
                    end
          S_RSTART: state <= S_RADDR;
          S_RADDR:  if (bus_nack) begin state <= S_STOP; res <= RES_DEV; end
                    else state <= S_RCNT;
          S_RCNT:   begin
                      d0_r <= bus_rxd;
                      xidx <= '0;
                      if (bus_rxd == 8'd0 || {1'b0, bus_rxd} > MAXCNT) begin
                        state <= S_STOP; res <= RES_FAIL;
                      end else state <= S_RDATA;
                    end
          S_RDATA:  begin
                      xidx <= xidx + 8'd1;
                      if (at_end) state <= S_STOP;
                    end
          S_STOP:   begin
                      state <= S_IDLE;
                      case (res)
                        RES_OK:  st_intr <= 1'b1;
                        RES_DEV: st_dev  <= 1'b1;
                        default: st_fail <= 1'b1;
                      endcase
                    end
          default:  state <= S_IDLE;
        endcase
        if (kill_pend && state != S_STOP) begin
          state <= S_STOP;
          res <= RES_FAIL;
        end
      end
    end
  end

  assert_stop_before_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(bus_op == OP_STOP && bus_done));

  assert_flag_on_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> (st_intr || st_dev || st_fail));

  assert_op_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> ($stable(bus_op) && $stable(bus_txd) && $stable(bus_last)));

  assert_index_in_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RDATA || state == S_WDATA) |-> (xidx < d0_r && {1'b0, d0_r} <= MAXCNT));
endmodule

// File: tb/tb_smbus_blk_host.sv
module tb_smbus_blk_host;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic bus_req, bus_last;
  logic [1:0] bus_op;
  logic [7:0] bus_txd;
  logic bus_done = 1'b0, bus_nack = 1'b0;
  logic [7:0] bus_rxd = '0;

  int total = 0, bad = 0;
  logic [10:0] expq[$];
  logic [7:0] rxq[$];
  int nack_at = -1, wcount = 0;
  bit stall = 1'b0, req_seen = 1'b0, finished = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;

  smbus_blk_host dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] b, input logic last);
    expq.push_back({op, b, last});
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(4'h0, s);
      if (!s[0]) break;
    end
  endtask

  task automatic wait_req();
    while (!bus_req) @(negedge clk);
  endtask

  // bus master model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      bus_done = 1'b0;
      bus_nack = 1'b0;
      if (bus_req) begin
        req_seen = 1'b1;
        while (stall) @(negedge clk);
        repeat (2) @(negedge clk);
        total++;
        if (expq.size() == 0) begin
          bad++;
          $display("FAIL %s unexpected op act=%h exp=none", tag, {bus_op, bus_txd, bus_last});
        end else begin
          logic [10:0] e;
          e = expq.pop_front();
          if ({bus_op, bus_txd, bus_last} !== e) begin
            bad++;
            $display("FAIL %s bus op act=%h exp=%h", tag, {bus_op, bus_txd, bus_last}, e);
          end
        end
        if (bus_op == 2'd1) begin
          bus_nack = (wcount == nack_at);
          wcount++;
        end
        if (bus_op == 2'd2) bus_rxd = (rxq.size() != 0) ? rxq.pop_front() : 8'hEE;
        bus_done = 1'b1;
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic expect_write(input logic [7:0] c, input logic [7:0] n, input logic [7:0] b0,
                              input logic [7:0] b1, input logic [7:0] b2);
    push(2'd0, 8'h00, 1'b0); push(2'd1, 8'hA0, 1'b0); push(2'd1, c, 1'b0);
    push(2'd1, n, 1'b0); push(2'd1, b0, 1'b0); push(2'd1, b1, 1'b0);
    push(2'd1, b2, 1'b0); push(2'd3, 8'h00, 1'b0);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    tag = "R1";
    chk("R1 bus_req", bus_req, 0);
    rd(4'h0, v); chk("R1 status", v, 8'h00);
    rd(4'h2, v); chk("R1 control", v, 8'h00);

    // R2 block write of three bytes
    tag = "R2";
    wr(4'hD, 8'h02);
    rd(4'h2, v);
    wr(4'h7, 8'hA5); wr(4'h7, 8'h5A); wr(4'h7, 8'h3C);
    wr(4'h5, 8'h03); wr(4'h4, 8'hA0); wr(4'h3, 8'h12); wr(4'h0, 8'hFF);
    expect_write(8'h12, 8'h03, 8'hA5, 8'h5A, 8'h3C);
    wr(4'h2, 8'h54);
    wait_idle();
    chk("R2 seq drained", expq.size(), 0);
    rd(4'h0, v); chk("R2 complete", v, 8'h42);

    // R9 write-one-to-clear, R10 in-use set by read
    wr(4'h0, 8'h02); rd(4'h0, v); chk("R9 w1c partial", v, 8'h40);
    wr(4'h0, 8'h40); rd(4'h0, v); chk("R10 cleared read", v, 8'h00);
    rd(4'h0, v); chk("R10 set by read", v, 8'h40);

    // R3 block read of four bytes
    tag = "R3";
    wr(4'h0, 8'hFF);
    wr(4'h4, 8'hA1); wr(4'h3, 8'h20);
    rxq = '{8'd4, 8'h11, 8'h22, 8'h33, 8'h44};
    push(2'd0, 8'h00, 1'b0); push(2'd1, 8'hA0, 1'b0); push(2'd1, 8'h20, 1'b0);
    push(2'd0, 8'h00, 1'b0); push(2'd1, 8'hA1, 1'b0);
    push(2'd2, 8'h00, 1'b0); push(2'd2, 8'h00, 1'b0); push(2'd2, 8'h00, 1'b0);
    push(2'd2, 8'h00, 1'b0); push(2'd2, 8'h00, 1'b1); push(2'd3, 8'h00, 1'b0);
    wr(4'h2, 8'h54);
    wait_idle();
    chk("R3 seq drained", expq.size(), 0);
    rd(4'h0, v); chk("R3 complete", v, 8'h42);
    rd(4'h5, v); chk("R3 count in data0", v, 8'd4);
    rd(4'h2, v);
    rd(4'h7, v); chk("R4 port byte0", v, 8'h11);
    rd(4'h7, v); chk("R4 port byte1", v, 8'h22);
    rd(4'h7, v); chk("R4 port byte2", v, 8'h33);
    rd(4'h7, v); chk("R4 port byte3", v, 8'h44);

    // R4 index frozen with auxiliary bit 1 clear
    wr(4'hD, 8'h00);
    rd(4'h2, v);
    wr(4'h7, 8'h66); wr(4'h7, 8'h77);
    rd(4'h7, v); chk("R4 no advance", v, 8'h77);
    wr(4'hD, 8'h02);
    rd(4'h2, v); rd(4'h7, v); chk("R4 rewind", v, 8'h77);
    rd(4'h7, v); chk("R4 advance", v, 8'h22);

    // R6 received count of zero, then 33
    tag = "R6";
    for (int k = 0; k < 2; k++) begin
      wr(4'h0, 8'hFF);
      rxq = '{(k == 0) ? 8'd0 : 8'd33};
      push(2'd0, 8'h00, 1'b0); push(2'd1, 8'hA0, 1'b0); push(2'd1, 8'h20, 1'b0);
      push(2'd0, 8'h00, 1'b0); push(2'd1, 8'hA1, 1'b0);
      push(2'd2, 8'h00, 1'b0); push(2'd3, 8'h00, 1'b0);
      wr(4'h2, 8'h54);
      wait_idle();
      chk("R6 seq drained", expq.size(), 0);
      rd(4'h0, v); chk("R6 failed", v, 8'h50);
      rd(4'h5, v); chk("R6 count kept", v, (k == 0) ? 8'd0 : 8'd33);
    end

    // R5 NACK on the command byte of a write
    tag = "R5";
    wr(4'h0, 8'hFF);
    wr(4'h4, 8'hA0); wr(4'h5, 8'h03); wr(4'h3, 8'h12);
    rd(4'h2, v);
    wr(4'h7, 8'hA5); wr(4'h7, 8'h5A); wr(4'h7, 8'h3C);
    wcount = 0; nack_at = 1;
    push(2'd0, 8'h00, 1'b0); push(2'd1, 8'hA0, 1'b0); push(2'd1, 8'h12, 1'b0);
    push(2'd3, 8'h00, 1'b0);
    wr(4'h2, 8'h54);
    wait_idle();
    nack_at = -1;
    chk("R5 seq drained", expq.size(), 0);
    rd(4'h0, v); chk("R5 device error", v, 8'h44);

    // R7 kill during a transaction
    tag = "R7";
    wr(4'h0, 8'hFF);
    stall = 1'b1;
    push(2'd0, 8'h00, 1'b0); push(2'd3, 8'h00, 1'b0);
    wr(4'h2, 8'h54);
    wait_req();
    rd(4'h0, v); chk("R9 busy while running", v[0], 1'b1);
    wr(4'h2, 8'h16);
    stall = 1'b0;
    wait_idle();
    chk("R7 seq drained", expq.size(), 0);
    rd(4'h0, v); chk("R7 failed after kill", v, 8'h50);

    // R8 start and command write while busy ignored
    tag = "R8";
    wr(4'h0, 8'hFF);
    stall = 1'b1;
    expect_write(8'h12, 8'h03, 8'hA5, 8'h5A, 8'h3C);
    wr(4'h2, 8'h54);
    wait_req();
    wr(4'h2, 8'h54);
    wr(4'h3, 8'h77);
    stall = 1'b0;
    wait_idle();
    chk("R8 seq drained", expq.size(), 0);
    rd(4'h0, v); chk("R8 complete", v, 8'h42);
    rd(4'h3, v); chk("R8 command kept", v, 8'h12);

    // R11 bad protocol and zero write count
    tag = "R11";
    wr(4'h0, 8'hFF);
    req_seen = 1'b0;
    wr(4'h2, 8'h4C);
    repeat (6) @(negedge clk);
    chk("R11 no request bad protocol", req_seen, 1'b0);
    rd(4'h0, v); chk("R11 failed bad protocol", v, 8'h10);
    wr(4'h0, 8'hFF);
    wr(4'h5, 8'h00);
    wr(4'h2, 8'h54);
    repeat (6) @(negedge clk);
    chk("R11 no request zero count", req_seen, 1'b0);
    rd(4'h0, v); chk("R11 failed zero count", v, 8'h10);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule